// File: doc/BRIEF.md
# Pseudo-Random Memory Test Sequencer

This block drives the host port of a word-addressed memory controller to prove that a range of memory stores data faithfully. It loads a pseudo-random generator with a fixed seed. It then writes the generator's successive outputs to successive addresses across a configured range. Next it loads the same seed into the generator again, reads the range back in the same order, and compares each returned word with the value the generator produces again. No copy of the written data is kept anywhere. A four-bit status code, meant for a single 7-segment digit, shows the current phase and then the verdict.

The memory side uses a request/begin/done handshake. A read or write request is held high, together with its address and data, until the controller pulses `mem_begun`. On that edge the request is taken and the sequencer moves to the next address. If the request stays high, the next word enters the controller's pipeline at once. Completions come back on `mem_done`, with read data on `mem_rdata`, in the order the requests were issued. The sequencer counts the completions, not the issued requests, to decide when a phase is over.

The states are as follows:
- `S_SEED`: the generator holds the seed and the counters clear. After one cycle the block moves to `S_WRITE`.
- `S_WRITE`: writes are issued. When the last write completes, the block moves to `S_RESEED`.
- `S_RESEED`: the generator reloads the seed. After one cycle the block moves to `S_READ`.
- `S_READ`: reads are issued and their data is compared. When the last read completes, the block moves to `S_PASS` if every word matched, or to `S_FAIL` otherwise.
- `S_PASS` and `S_FAIL`: both are terminal and are left only by reset.

Top module: `memtest_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `mem_rd` and `mem_wr` are low and `status` is 4'h2.
- R2: The word written to the first address equals `SEED`. Each following word is the previous one shifted left by one bit, with bit 0 set to the XOR of bits 15, 14, 12 and 3 of the previous word (16-bit data). The generator advances only when a write is taken.
- R3: In `S_WRITE`, `mem_wr` stays high while the address runs from `START_ADDR` up to `END_ADDR`. The address advances only on a cycle with `mem_begun` high. `mem_wr` falls after the write at `END_ADDR` is taken.
- R4: When the completion count of the write phase reaches the number of words, one cycle of `S_RESEED` follows, and then the read phase starts.
- R5: In `S_READ`, `mem_rd` stays high while the address runs from `START_ADDR` up to `END_ADDR`, advancing on `mem_begun`, so several reads can be outstanding at once. `mem_rd` falls after the read at `END_ADDR` is taken.
- R6: On each `mem_done` in the read phase, `mem_rdata` is compared with the regenerated sequence in issue order, and the generator advances once. When all words match, `status` ends at 4'h0.
- R7: `status` is 4'h2 in `S_SEED` and `S_WRITE`, 4'h3 in `S_RESEED` and `S_READ`, 4'h0 in `S_PASS` and 4'hE in `S_FAIL`.
- R8: A single mismatch at any word leads to 4'hE, even if every later word matches.
- R9: Once the verdict is shown, `status` holds and `mem_rd` and `mem_wr` stay low until reset, whatever happens on `mem_begun` and `mem_done`.
- R10: `mem_rd` and `mem_wr` are never high together. While a write waits for `mem_begun`, its address and data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| mem_rd | output | 1 | Read request to the memory controller |
| mem_wr | output | 1 | Write request to the memory controller |
| mem_addr | output | ADDR_W | Word address of the current request |
| mem_wdata | output | DATA_W | Data for the current write |
| mem_begun | input | 1 | The controller has taken the pending request this cycle |
| mem_done | input | 1 | One operation has completed this cycle |
| mem_rdata | input | DATA_W | Read data, valid on a read `mem_done` |
| status | output | 4 | Phase/verdict code: 2, 3, 0 or E |

## Verification
The memory model in the bench returns read data two cycles late, so up to three reads are in flight. A design that compared each word against the generator value at issue time, rather than at completion time, would report false mismatches. Random stalls on `mem_begun` check that the address and data are held while a request waits; a design that advanced on the request alone would skip words. Single-bit corruption is injected at the first and at the last address. A design whose failure flag was not sticky would show 0 for the first case, and one that dropped the last comparison would show 0 for the second. Spurious `mem_begun` and `mem_done` pulses after the verdict confirm that the terminal states hold.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

    typedef enum logic [2:0] {
        S_SEED   = 3'd0,
        S_WRITE  = 3'd1,
        S_RESEED = 3'd2,
        S_READ   = 3'd3,
        S_PASS   = 3'd4,
        S_FAIL   = 3'd5
    } seq_state_t;

    localparam logic [3:0] CODE_WRITE = 4'h2;
    localparam logic [3:0] CODE_READ  = 4'h3;
    localparam logic [3:0] CODE_PASS  = 4'h0;
    localparam logic [3:0] CODE_FAIL  = 4'hE;

    // Feedback masks for maximal-length Fibonacci generators (bit i = tap i+1)
    function automatic logic [63:0] fib_mask(input int width);
        case (width)
            8:       return 64'h0000_0000_0000_00B8;
            24:      return 64'h0000_0000_00E1_0000;
            32:      return 64'h0000_0000_8020_0003;
            default: return 64'h0000_0000_0000_D008;
        endcase
    endfunction

endpackage

// File: rtl/lfsr_gen.sv
module lfsr_gen #(
    parameter int          WIDTH = 16,
    parameter logic [WIDTH-1:0] SEED = 'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    output logic [WIDTH-1:0] value
);
    import memtest_pkg::*;

    localparam logic [63:0]      MASK64 = fib_mask(WIDTH);
    localparam logic [WIDTH-1:0] MASK   = MASK64[WIDTH-1:0];

    logic [WIDTH-1:0] q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)       q <= SEED;
        else if (load) q <= SEED;
        else if (step) q <= {q[WIDTH-2:0], ^(q & MASK)};
    end

    assign value = q;

    // A maximal-length sequence started from a nonzero seed never reaches zero
    assert_nonzero_R2: assert property (@(posedge clk) disable iff (rst) q != '0);

endmodule

// File: rtl/addr_walker.sv
module addr_walker #(
    parameter int ADDR_W     = 8,
    parameter int START_ADDR = 4,
    parameter int END_ADDR   = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(START_ADDR);
    localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(END_ADDR);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)                     addr_q <= A_FIRST;
        else if (restart)            addr_q <= A_FIRST;
        else if (advance && !at_last) addr_q <= addr_q + 1'b1;
    end

    assign addr    = addr_q;
    assign at_last = (addr_q == A_LAST);

    assert_range_R3: assert property (@(posedge clk) disable iff (rst)
        (addr_q >= A_FIRST) && (addr_q <= A_LAST));

endmodule

// File: rtl/memtest_seq.sv
module memtest_seq #(
    parameter int                DATA_W     = 16,
    parameter int                ADDR_W     = 8,
    parameter int                START_ADDR = 4,
    parameter int                END_ADDR   = 19,
    parameter logic [DATA_W-1:0] SEED       = 'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_begun,
    input  logic              mem_done,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [3:0]        status
);
    import memtest_pkg::*;

    localparam int NWORDS = END_ADDR - START_ADDR + 1;
    localparam int CNT_W  = $clog2(NWORDS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NWORDS - 1);

    seq_state_t       state_q, state_d;
    logic             fail_q;
    logic             issued_q;
    logic [CNT_W-1:0] cnt_q;

    logic              in_wr, in_rd, restart, accept, at_last, mismatch, last_done;
    logic [DATA_W-1:0] gen_value;
    logic [ADDR_W-1:0] walk_addr;

    assign in_wr     = (state_q == S_WRITE);
    assign in_rd     = (state_q == S_READ);
    assign restart   = (state_q == S_SEED) || (state_q == S_RESEED);
    assign accept    = mem_begun && (mem_rd || mem_wr);
    assign mismatch  = (mem_rdata != gen_value);
    assign last_done = mem_done && (cnt_q == LAST_CNT);

    lfsr_gen #(.WIDTH(DATA_W), .SEED(SEED)) u_gen (
        .clk   (clk),
        .rst   (rst),
        .load  (restart),
        .step  ((in_wr && accept) || (in_rd && mem_done)),
        .value (gen_value)
    );

    addr_walker #(.ADDR_W(ADDR_W), .START_ADDR(START_ADDR), .END_ADDR(END_ADDR)) u_walk (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .advance (accept),
        .addr    (walk_addr),
        .at_last (at_last)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_SEED:   state_d = S_WRITE;
            S_WRITE:  if (last_done) state_d = S_RESEED;
            S_RESEED: state_d = S_READ;
            S_READ:   if (last_done) state_d = (fail_q || mismatch) ? S_FAIL : S_PASS;
            S_PASS:   state_d = S_PASS;
            S_FAIL:   state_d = S_FAIL;
        endcase
    end

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= S_SEED;
        else     state_q <= state_d;
    end

    // Issue flag, completion counter and sticky failure flag
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            issued_q <= 1'b0;
            cnt_q    <= '0;
            fail_q   <= 1'b0;
        end else begin
            if (restart)                  issued_q <= 1'b0;
            else if (accept && at_last)   issued_q <= 1'b1;
            if (restart)                  cnt_q <= '0;
            else if ((in_wr || in_rd) && mem_done) cnt_q <= cnt_q + 1'b1;
            if (in_rd && mem_done && mismatch) fail_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        mem_wr    = in_wr && !issued_q;
        mem_rd    = in_rd && !issued_q;
        mem_addr  = walk_addr;
        mem_wdata = gen_value;
        unique case (state_q)
            S_SEED, S_WRITE:  status = CODE_WRITE;
            S_RESEED, S_READ: status = CODE_READ;
            S_PASS:           status = CODE_PASS;
            S_FAIL:           status = CODE_FAIL;
            default:          status = CODE_FAIL;
        endcase
    end

    assert_excl_R10: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_begun) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    assert_pass_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_PASS) |=> (state_q == S_PASS));

    assert_fail_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_FAIL) |=> (state_q == S_FAIL));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst) fail_q |=> fail_q);

    assert_reseed_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RESEED) |=> (state_q == S_READ));

endmodule

// File: tb/sim_memtest_seq.sv
`timescale 1ns/1ps
module sim_memtest_seq;
    localparam int          START = 4;
    localparam int          LAST  = 19;
    localparam int          NW    = LAST - START + 1;
    localparam logic [15:0] SEED  = 16'hACE1;
    localparam int          LAT   = 2;

    localparam int PH_SEED = 0, PH_WR = 1, PH_RS = 2, PH_RD = 3, PH_PASS = 4, PH_FAIL = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_rd, mem_wr, mem_begun, mem_done;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [3:0]  status;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    int  m_ph, m_addr, m_cnt;
    bit  m_iss, m_fail;
    logic [15:0] m_lfsr;

    bit stall_en = 0;
    bit spur_en  = 0;
    int bad_addr = -1;

    logic [15:0] memarr [0:255];
    int          q_due[$];
    logic [15:0] q_dat[$];

    always #4 clk = ~clk;

    memtest_seq u0 (
        .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_begun(mem_begun),
        .mem_done(mem_done), .mem_rdata(mem_rdata), .status(status)
    );

    function automatic logic [15:0] nx(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Memory controller model and cycle-by-cycle reference model
    initial begin
        mem_begun = 0; mem_done = 0; mem_rdata = '0;
        for (int i = 0; i < 256; i++) memarr[i] = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst) begin
                m_ph = PH_SEED; m_addr = START; m_cnt = 0; m_iss = 0; m_fail = 0; m_lfsr = SEED;
                q_due.delete(); q_dat.delete();
                mem_begun = 0; mem_done = 0;
            end else begin
                // update model with the handshake seen at the last rising edge
                case (m_ph)
                    PH_SEED: begin m_lfsr = SEED; m_addr = START; m_cnt = 0; m_iss = 0; m_ph = PH_WR; end
                    PH_WR: begin
                        if (mem_begun && !m_iss) begin
                            m_lfsr = nx(m_lfsr);
                            if (m_addr == LAST) m_iss = 1; else m_addr++;
                        end
                        if (mem_done) begin m_cnt++; if (m_cnt == NW) m_ph = PH_RS; end
                    end
                    PH_RS: begin m_lfsr = SEED; m_addr = START; m_cnt = 0; m_iss = 0; m_ph = PH_RD; end
                    PH_RD: begin
                        if (mem_begun && !m_iss) begin
                            if (m_addr == LAST) m_iss = 1; else m_addr++;
                        end
                        if (mem_done) begin
                            if (mem_rdata != m_lfsr) m_fail = 1;
                            m_lfsr = nx(m_lfsr);
                            m_cnt++;
                            if (m_cnt == NW) m_ph = m_fail ? PH_FAIL : PH_PASS;
                        end
                    end
                    default: ;
                endcase
                // compare outputs with the model
                begin
                    logic [3:0] es;
                    string      st;
                    es = (m_ph <= PH_WR) ? 4'h2 : (m_ph <= PH_RD) ? 4'h3 : (m_ph == PH_PASS) ? 4'h0 : 4'hE;
                    st = (m_ph >= PH_PASS) ? "R9 status" : "R7 status";
                    chk(status == es, st, status, es);
                    chk(mem_wr == (m_ph == PH_WR && !m_iss), (m_ph >= PH_PASS) ? "R9 wr" : "R3 wr", mem_wr, (m_ph == PH_WR && !m_iss));
                    chk(mem_rd == (m_ph == PH_RD && !m_iss), (m_ph >= PH_PASS) ? "R9 rd" : "R5 rd", mem_rd, (m_ph == PH_RD && !m_iss));
                    chk(!(mem_rd && mem_wr), "R10 exclusive", {mem_rd, mem_wr}, 0);
                    if (m_ph == PH_WR && !m_iss) begin
                        chk(mem_addr == 8'(m_addr), "R3 addr", mem_addr, m_addr);
                        chk(mem_wdata == m_lfsr, "R2 wdata", mem_wdata, m_lfsr);
                    end
                    if (m_ph == PH_RD && !m_iss)
                        chk(mem_addr == 8'(m_addr), "R5 addr", mem_addr, m_addr);
                end
                // drive the next handshake values
                mem_begun = 0; mem_done = 0;
                if ((mem_wr || mem_rd) && !(stall_en && ($urandom % 3 == 0))) mem_begun = 1;
                if (mem_begun && mem_wr) begin memarr[mem_addr] = mem_wdata; mem_done = 1; end
                if (mem_begun && mem_rd) begin
                    logic [15:0] d;
                    d = memarr[mem_addr];
                    if (int'(mem_addr) == bad_addr) d = d ^ 16'h0100;
                    q_due.push_back(cyc + LAT);
                    q_dat.push_back(d);
                end
                if (q_due.size() > 0 && q_due[0] == cyc) begin
                    mem_done  = 1;
                    mem_rdata = q_dat[0];
                    void'(q_due.pop_front());
                    void'(q_dat.pop_front());
                end
                if (spur_en && m_ph >= PH_PASS && ($urandom % 2 == 0)) begin
                    mem_begun = 1; mem_done = 1; mem_rdata = ~mem_rdata;
                end
            end
        end
    end

    task automatic run_test(input bit stall, input int badw, input bit spur, input logic [3:0] exp_code, input string tag);
        @(negedge clk); #1;
        rst = 1; stall_en = stall; bad_addr = badw; spur_en = spur;
        repeat (3) @(negedge clk);
        #1;
        chk(status == 4'h2, "R1 reset status", status, 4'h2);
        chk(!mem_rd && !mem_wr, "R1 reset requests", {mem_rd, mem_wr}, 0);
        rst = 0;
        begin
            int i;
            for (i = 0; i < 5000 && !(m_ph >= PH_PASS); i++) begin @(negedge clk); #2; end
            if (!(m_ph >= PH_PASS)) chk(0, "watchdog", i, 0);
        end
        repeat (20) @(negedge clk);
        #2;
        chk(status == exp_code, tag, status, exp_code);
    endtask

    initial begin
        run_test(0, -1,    0, 4'h0, "R6 clean pass");
        run_test(1, -1,    0, 4'h0, "R6 pass with stalls");
        run_test(0, START, 1, 4'hE, "R8 first word bad, sticky");
        run_test(1, LAST,  1, 4'hE, "R8 last word bad");
        run_test(1, 10,    0, 4'hE, "R8 middle word bad");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule